// File: doc/BRIEF.md
# Accumulator Fetch-Execute Sequencer

This block is a minimal 8-bit processor core. It steps through a program held in an external byte-wide memory. It drives a 16-bit address with a read strobe and takes each byte back on an 8-bit data input one cycle later. Every byte it reads is either an opcode or the immediate operand that follows an opcode.

The instruction set has three opcodes:
- load an immediate into the accumulator;
- add an immediate to the accumulator;
- halt.

Any other opcode also stops the core. The core has four 8-bit working registers, and only the accumulator is written by the instruction set. The accumulator is visible on an output. A halted flag shows that the fetch loop has frozen, and the loop stays frozen until reset.

Top module: `acc_seq_core`

## Requirements
- R1: While reset is asserted and right after it is released, the address output is 1400h, the accumulator reads 00h and the halted flag is low. The first read after reset is at 1400h.
- R2: A read drives the address with the read strobe high for one cycle. The data input is sampled in the following cycle, and the strobe is never high in two consecutive cycles.
- R3: Opcode B0h copies the byte at the next address into the accumulator. The accumulator changes only when an instruction completes.
- R4: Opcode 04h adds the byte at the next address to the accumulator, modulo 256 (F0h + 20h gives 10h).
- R5: Opcode F4h raises the halted flag two cycles after its fetch strobe. After that no read strobe occurs, and the address stays at the halt opcode's address.
- R6: Any opcode other than B0h, 04h and F4h halts the core in the same way as F4h, and leaves the accumulator unchanged.
- R7: Each immediate instruction takes four cycles and advances the program counter by 2. The reads occur at consecutive addresses in program order.
- R8: The halted state persists until reset. A reset in the middle of a program restarts execution from 1400h with the accumulator cleared.
- R9: The program B0 21, 04 42, 04 12, F4 placed at 1400h ends with the accumulator at 75h and the address held at 1406h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_addr_o | output | 16 | Memory read address |
| mem_rd_o | output | 1 | Read strobe |
| mem_data_i | input | 8 | Read data, valid the cycle after the strobe |
| halted_o | output | 1 | Core has stopped fetching |
| acc_o | output | 8 | Accumulator contents |

## Verification
In the execute cycle, two things land on the same clock edge: the accumulator write-back and the 2-byte program counter step. The next opcode fetch then starts from the advanced address using the freshly written accumulator. Back-to-back instructions provoke this. The bench judges it by sampling the accumulator exactly at the fourth, eighth and twelfth cycle after reset, and by comparing the logged read addresses with the contiguous expected sequence. A second collision, a reset arriving while an operand read is in flight, is provoked mid-program; the bench judges it by the restart address and the cleared accumulator.

// File: rtl/acc_seq_pkg.sv
`timescale 1ns/1ps
package acc_seq_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 16;

  localparam logic [DATA_W-1:0] OP_LDI  = 8'hB0;
  localparam logic [DATA_W-1:0] OP_ADDI = 8'h04;
  localparam logic [DATA_W-1:0] OP_HALT = 8'hF4;

  typedef enum logic [2:0] {
    ST_FETCH,   // opcode read strobe
    ST_OP_WAIT, // opcode arriving, decode
    ST_IMM,     // operand read strobe
    ST_EXEC,    // operand arriving, write back, step pc
    ST_HALT
  } seq_state_e;
endpackage

// File: rtl/acc_seq_pc.sv
`timescale 1ns/1ps
module acc_seq_pc #(
  parameter int              AW    = 16,
  parameter logic [AW-1:0]   START = 16'h1400,
  parameter int              STEP  = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_i,
  output logic [AW-1:0] pc_o
);
  localparam logic [AW-1:0] STEP_V = AW'(STEP);

  logic [AW-1:0] pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pc_q <= START;
    else if (step_i) pc_q <= pc_q + STEP_V;
  end

  assign pc_o = pc_q;

  p_pc_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_q != $past(pc_q)) |-> (pc_q == $past(pc_q) + STEP_V))
    else $error("pc moved by other than one instruction length");
endmodule

// File: rtl/acc_seq_regfile.sv
`timescale 1ns/1ps
module acc_seq_regfile #(
  parameter int DW   = 8,
  parameter int NREG = 4,
  localparam int IW  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [IW-1:0] wr_idx_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic [DW-1:0] rd_data_o
);
  logic [DW-1:0] regs_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  regs_q[g] <= '0;
      else if (wr_en_i && (wr_idx_i == IW'(g)))     regs_q[g] <= wr_data_i;
    end
  end

  assign rd_data_o = regs_q[rd_idx_i];

  p_acc_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && $stable(rd_idx_i)) |=> $stable(rd_data_o))
    else $error("register changed without a write");
endmodule

// File: rtl/acc_seq_ctrl.sv
`timescale 1ns/1ps
module acc_seq_ctrl
  import acc_seq_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] data_i,
  output logic          rd_o,
  output logic          sel_operand_o,
  output logic          pc_step_o,
  output logic          wr_en_o,
  output logic          wr_add_o,
  output logic          halted_o
);
  seq_state_e state_q, state_d;
  logic       add_q, add_d;

  always_comb begin
    state_d       = state_q;
    add_d         = add_q;
    rd_o          = 1'b0;
    sel_operand_o = 1'b0;
    pc_step_o     = 1'b0;
    wr_en_o       = 1'b0;
    halted_o      = 1'b0;
    unique case (state_q)
      ST_FETCH: begin
        rd_o    = 1'b1;
        state_d = ST_OP_WAIT;
      end
      ST_OP_WAIT: begin
        if (data_i == DW'(OP_LDI)) begin
          add_d   = 1'b0;
          state_d = ST_IMM;
        end else if (data_i == DW'(OP_ADDI)) begin
          add_d   = 1'b1;
          state_d = ST_IMM;
        end else begin
          state_d = ST_HALT; // explicit halt and undefined codes
        end
      end
      ST_IMM: begin
        rd_o          = 1'b1;
        sel_operand_o = 1'b1;
        state_d       = ST_EXEC;
      end
      ST_EXEC: begin
        wr_en_o   = 1'b1;
        pc_step_o = 1'b1;
        state_d   = ST_FETCH;
      end
      ST_HALT: halted_o = 1'b1;
      default: state_d = ST_HALT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_FETCH;
      add_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      add_q   <= add_d;
    end
  end

  assign wr_add_o = add_q;

  p_one_read_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_o |=> !rd_o)
    else $error("read strobe in consecutive cycles");
  p_halt_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |-> (!rd_o && !pc_step_o && !wr_en_o))
    else $error("activity while halted");
  p_halt_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> halted_o)
    else $error("halt released without reset");
endmodule

// File: rtl/acc_seq_core.sv
`timescale 1ns/1ps
module acc_seq_core
  import acc_seq_pkg::*;
#(
  parameter logic [ADDR_W-1:0] START_ADDR = 16'h1400,
  parameter int                NUM_REGS   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_rd_o,
  input  logic [DATA_W-1:0] mem_data_i,
  output logic              halted_o,
  output logic [DATA_W-1:0] acc_o
);
  localparam int IW      = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam int INSN_SZ = 2;

  logic              sel_operand, pc_step, wr_en, wr_add;
  logic [ADDR_W-1:0] pc;
  logic [DATA_W-1:0] acc, sum, wr_data;

  acc_seq_ctrl #(.DW(DATA_W)) u_ctrl (
    .clk_i, .rst_ni,
    .data_i        (mem_data_i),
    .rd_o          (mem_rd_o),
    .sel_operand_o (sel_operand),
    .pc_step_o     (pc_step),
    .wr_en_o       (wr_en),
    .wr_add_o      (wr_add),
    .halted_o      (halted_o)
  );

  acc_seq_pc #(.AW(ADDR_W), .START(START_ADDR), .STEP(INSN_SZ)) u_pc (
    .clk_i, .rst_ni,
    .step_i (pc_step),
    .pc_o   (pc)
  );

  // carry out of the add is dropped
  assign sum     = acc + mem_data_i;
  assign wr_data = wr_add ? sum : mem_data_i;

  acc_seq_regfile #(.DW(DATA_W), .NREG(NUM_REGS)) u_regs (
    .clk_i, .rst_ni,
    .wr_en_i   (wr_en),
    .wr_idx_i  ('0),
    .wr_data_i (wr_data),
    .rd_idx_i  ('0),
    .rd_data_o (acc)
  );

  assign mem_addr_o = pc + ADDR_W'(sel_operand);
  assign acc_o      = acc;

  p_halt_addr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halted_o && $past(halted_o)) |-> $stable(mem_addr_o))
    else $error("address moved while halted");
endmodule

// File: tb/acc_seq_core_test.sv
`timescale 1ns/1ps
module acc_seq_core_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr;
  logic        rd;
  logic [7:0]  data_q = '0;
  logic        halted;
  logic [7:0]  acc;

  int checks = 0;
  int errors = 0;

  logic [7:0]  mem [256];
  logic [15:0] rlog [64];
  int          rcnt = 0;

  always #10 clk = ~clk;

  acc_seq_core uut (
    .clk_i(clk), .rst_ni(rst_n),
    .mem_addr_o(addr), .mem_rd_o(rd), .mem_data_i(data_q),
    .halted_o(halted), .acc_o(acc)
  );

  // one-cycle latency memory, program window 1400h..14FFh
  always @(posedge clk) if (rd) data_q <= (addr[15:8] == 8'h14) ? mem[addr[7:0]] : 8'h00;

  always @(posedge clk) if (rst_n && rd) begin
    if (rcnt < 64) rlog[rcnt] = addr;
    rcnt++;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start();
    @(negedge clk);
    rst_n = 1'b0;
    step(2);
    rcnt = 0;
    rst_n = 1'b1;
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
  endtask

  task automatic load_example();
    clear_mem();
    mem[0] = 8'hB0; mem[1] = 8'h21; mem[2] = 8'h04; mem[3] = 8'h42;
    mem[4] = 8'h04; mem[5] = 8'h12; mem[6] = 8'hF4;
  endtask

  task automatic t_reset();
    load_example();
    @(negedge clk);
    rst_n = 1'b0;
    step(1);
    check(addr == 16'h1400, "R1 reset address", addr, 16'h1400);
    check(acc == 8'h00, "R1 reset acc", acc, 0);
    check(!halted, "R1 reset halted", halted, 0);
  endtask

  task automatic t_example();
    load_example();
    start();
    check(addr == 16'h1400 && rd, "R1 first read at start address", addr, 16'h1400);
    step(1);
    check(!rd, "R2 no strobe in wait cycle", rd, 0);
    step(2);
    check(acc == 8'h00, "R3 acc before load completes", acc, 0);
    step(1);
    check(acc == 8'h21, "R3 load immediate", acc, 8'h21);
    step(4);
    check(acc == 8'h63, "R4 add immediate", acc, 8'h63);
    step(4);
    check(acc == 8'h75, "R9 example result", acc, 8'h75);
    step(1);
    check(!halted, "R5 not halted during halt decode", halted, 0);
    step(1);
    check(halted, "R5 halted after F4", halted, 1);
    check(addr == 16'h1406, "R9 address frozen at halt", addr, 16'h1406);
    check(rcnt == 7, "R7 read count", rcnt, 7);
    for (int i = 0; i < 7 && i < rcnt; i++)
      check(rlog[i] == 16'h1400 + 16'(i), "R7 read order", rlog[i], 16'h1400 + i);
    step(10);
    check(rcnt == 7 && !rd, "R5 no reads while halted", rcnt, 7);
    check(halted && addr == 16'h1406 && acc == 8'h75, "R8 halt persists", acc, 8'h75);
  endtask

  task automatic t_wrap();
    clear_mem();
    mem[0] = 8'hB0; mem[1] = 8'hF0; mem[2] = 8'h04; mem[3] = 8'h20;
    mem[4] = 8'h04; mem[5] = 8'hFF; mem[6] = 8'hF4;
    start();
    step(8);
    check(acc == 8'h10, "R4 modulo 256 add", acc, 8'h10);
    step(4);
    check(acc == 8'h0F, "R4 add of FFh wraps", acc, 8'h0F);
    step(2);
    check(halted && addr == 16'h1406, "R7 pc after three instructions", addr, 16'h1406);
  endtask

  task automatic t_undef();
    clear_mem();
    mem[0] = 8'hB0; mem[1] = 8'h33; mem[2] = 8'h7F; mem[3] = 8'h04; mem[4] = 8'h01;
    start();
    step(6);
    check(halted, "R6 undefined opcode halts", halted, 1);
    check(addr == 16'h1402, "R6 address at undefined opcode", addr, 16'h1402);
    step(8);
    check(acc == 8'h33, "R6 acc unchanged", acc, 8'h33);
    check(rcnt == 3 && !rd, "R6 no reads after undefined opcode", rcnt, 3);
  endtask

  task automatic t_midreset();
    load_example();
    start();
    step(7);
    check(acc == 8'h21, "R8 progress before reset", acc, 8'h21);
    rst_n = 1'b0;
    #1;
    check(acc == 8'h00 && addr == 16'h1400, "R8 async reset mid-run", acc, 0);
    step(2);
    rcnt = 0;
    rst_n = 1'b1;
    check(addr == 16'h1400 && rd, "R8 restart fetch", addr, 16'h1400);
    step(14);
    check(halted && acc == 8'h75, "R8 rerun result", acc, 8'h75);
  endtask

  initial begin
    t_reset();
    t_example();
    t_wrap();
    t_undef();
    t_midreset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule